// File: doc/BRIEF.md
# Parallel Flash Command Interface

This block models the command front end of a byte-wide parallel NOR flash. It watches write cycles on the host bus, recognises the two-write unlock handshake that must come before every command, and decodes the command byte that follows. Four commands are understood: reset to array reads, identification (autoselect) mode, single-byte program and whole-chip erase. A small internal register array stands in for the flash cells. Program and erase durations are modelled by a down-counter.

The read path returns one of three things. In normal operation it returns array contents. In identification mode it returns the maker and device codes. While an embedded operation runs, or after one has failed, it returns status bits. The host polls these bits to see whether the operation has finished, because the block has no ready pin.

A write cycle is a clock cycle with `cs` and `we` high. A read cycle is a clock cycle with `cs` and `rd` high. The controller states are:

- `S_IDLE`: array reads.
- `S_UNLK1`: first unlock write seen.
- `S_UNLK2`: both unlock writes seen; waiting for the command code.
- `S_PGM_SETUP`: waiting for the program data write.
- `S_ERS_U1`, `S_ERS_U2`: the second unlock pair after erase setup.
- `S_ERS_CMD`: waiting for the chip-erase code.
- `S_IDENT`: identification mode.
- `S_PGM_BUSY`: program running.
- `S_ERS_PRE`: erase, internal zero-fill phase.
- `S_ERS_MAIN`: erase, main phase.
- `S_FAIL`: program timed out.

The transitions are:

- `S_IDLE` goes to `S_UNLK1` on 0xAA written at 0x555.
- `S_UNLK1` goes to `S_UNLK2` on 0x55 written at 0x2AA.
- `S_UNLK2`, on a write at 0x555, goes to `S_IDENT` for 0x90, to `S_PGM_SETUP` for 0xA0, and to `S_ERS_U1` for 0x80.
- `S_PGM_SETUP` goes to `S_PGM_BUSY` on any write.
- `S_ERS_U1` goes to `S_ERS_U2` on 0xAA at 0x555.
- `S_ERS_U2` goes to `S_ERS_CMD` on 0x55 at 0x2AA.
- `S_ERS_CMD` goes to `S_ERS_PRE` on 0x10 at 0x555.
- `S_ERS_PRE` goes to `S_ERS_MAIN` when the timer expires.
- `S_ERS_MAIN` goes to `S_IDLE` when the timer expires.
- `S_PGM_BUSY` goes to `S_FAIL` when the timer expires if a bit was asked to rise, and to `S_IDLE` otherwise.
- `S_IDENT` and `S_FAIL` go to `S_IDLE` on 0xF0.
- Any other write during a sequence returns to `S_IDLE`.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset, every array location reads 0xFF and reads return array data.
- R2: A command is accepted only after 0xAA written at address 0x555 and then 0x55 written at address 0x2AA, with the code then written at 0x555. Any other write in that sequence, including an unknown code, returns the block to array reads without acting.
- R3: In identification mode, a read with address bits [1:0] = 0 returns MFG_ID and a read with bits [1:0] = 1 returns DEV_ID. Any other address returns 0x00. The mode persists over any number of reads and over writes other than 0xF0, and a 0xF0 write returns the block to array reads.
- R4: A 0xF0 write between the unlock cycles aborts the sequence.
- R5: Program needs four writes: the two unlock writes, 0xA0, then the data write at the target address. The cell becomes old AND data and reads back PGM_CYC cycles after the data write.
- R6: While a program runs, the status byte has bit 7 equal to the complement of data bit 7, and bits 5 to 0 equal to 0. Bit 6 reads 0 on the first status read and inverts on each later read.
- R7: If the program data has a 1 where the cell holds 0, then after PGM_CYC cycles the status byte keeps bits 7 and 6 as in R6 and shows bit 5 = 1. This holds until a 0xF0 write, and other writes are ignored.
- R8: Chip erase needs six writes: the unlock pair, 0x80, the unlock pair again, then 0x10, with all codes at 0x555. The array is first cleared to 0x00 and then set to 0xFF, and array reads resume PRE_CYC+ERS_CYC cycles after the last write.
- R9: During erase, status bit 7 reads 0, bits 6 and 2 both invert on each read starting from 0, and all other bits read 0.
- R10: All writes, including 0xF0, are ignored while a program or erase is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write strobe, sampled at the clock edge while cs is high |
| rd | input | 1 | Read strobe, one read per clock cycle while cs is high |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data or command byte |
| rdata | output | 8 | Array data, identification code or status byte |

## Verification
Command decoding is tried with:

- complete unlock sequences for each code;
- sequences cut short by 0xF0 after the first or second unlock write;
- a sequence ending in an unknown code.

Each truncated sequence is followed by a write that would alter a cell if the sequence had been taken, which separates a true abort from a silent acceptance.

Program is tried with:

- data that only clears bits, which must read back as old AND new;
- data that asks for a 0-to-1 change, which must end in the sticky timeout status.

Back-to-back status reads separate the toggle behaviour from a static value.

During erase, a 0xF0 write is sent before the final array check. Reading 0xFF everywhere then shows both that the write was ignored and that every cell was cleared.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNLK1,
        S_UNLK2,
        S_PGM_SETUP,
        S_ERS_U1,
        S_ERS_U2,
        S_ERS_CMD,
        S_IDENT,
        S_PGM_BUSY,
        S_ERS_PRE,
        S_ERS_MAIN,
        S_FAIL
    } fsm_state_t;

    typedef enum logic [1:0] {
        SEL_ARRAY,
        SEL_IDENT,
        SEL_STATUS
    } rd_sel_t;

    localparam logic [10:0] ADR_KEY1 = 11'h555;
    localparam logic [10:0] ADR_KEY2 = 11'h2AA;

    localparam logic [7:0] KEY1           = 8'hAA;
    localparam logic [7:0] KEY2           = 8'h55;
    localparam logic [7:0] CODE_IDENT     = 8'h90;
    localparam logic [7:0] CODE_PROGRAM   = 8'hA0;
    localparam logic [7:0] CODE_ERS_SETUP = 8'h80;
    localparam logic [7:0] CODE_CHIP_ERS  = 8'h10;
    localparam logic [7:0] CODE_RESET     = 8'hF0;

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // A load takes priority over the countdown.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Asserted in the last cycle of the interval, so the user moves on
    // exactly len cycles after the load.
    assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/flash_mem_array.sv
module flash_mem_array #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] idx,
    output logic [7:0]    cell_q,
    input  logic          pgm_en,
    input  logic [7:0]    pgm_data,
    input  logic          fill_en,
    input  logic [7:0]    fill_val
);

    logic [7:0] mem_q [DEPTH];

    // Each cell holds its value unless the whole array is filled or it is
    // the addressed cell of a program (which can only clear bits).
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= 8'hFF;
            end else if (fill_en) begin
                mem_q[g] <= fill_val;
            end else if (pgm_en && (idx == AW'(g))) begin
                mem_q[g] <= mem_q[g] & pgm_data;
            end
        end
    end

    assign cell_q = mem_q[idx];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int PGM_CYC = 8,
    parameter int PRE_CYC = 16,
    parameter int ERS_CYC = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [10:0]      addr_lo,
    input  logic [7:0]       wdata,
    input  logic [7:0]       cell_q,
    input  logic             tdone,
    output fsm_state_t       state,
    output rd_sel_t          rd_sel,
    output logic             st_dq7,
    output logic             st_dq5,
    output logic             st_ers,
    output logic             t_start,
    output logic [CNT_W-1:0] t_len,
    output logic             pgm_en,
    output logic             fill_en,
    output logic [7:0]       fill_val
);

    fsm_state_t state_q, state_d;
    logic       pbit7_q;
    logic       bad_q;

    logic at_key1, at_key2, is_reset;

    assign at_key1  = (addr_lo == ADR_KEY1);
    assign at_key2  = (addr_lo == ADR_KEY2);
    assign is_reset = (wdata == CODE_RESET);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Data bit 7 and the "bit would have to rise" flag, captured with the
    // program data write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pbit7_q <= 1'b0;
            bad_q   <= 1'b0;
        end else if (pgm_en) begin
            pbit7_q <= wdata[7];
            bad_q   <= |(wdata & ~cell_q);
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (wr_en && at_key1 && wdata == KEY1) state_d = S_UNLK1;
            end
            S_UNLK1: begin
                if (wr_en) state_d = (at_key2 && wdata == KEY2) ? S_UNLK2 : S_IDLE;
            end
            S_UNLK2: begin
                if (wr_en) begin
                    state_d = S_IDLE;
                    if (at_key1) begin
                        if (wdata == CODE_IDENT)     state_d = S_IDENT;
                        if (wdata == CODE_PROGRAM)   state_d = S_PGM_SETUP;
                        if (wdata == CODE_ERS_SETUP) state_d = S_ERS_U1;
                    end
                end
            end
            S_PGM_SETUP: begin
                if (wr_en) state_d = S_PGM_BUSY;
            end
            S_ERS_U1: begin
                if (wr_en) state_d = (at_key1 && wdata == KEY1) ? S_ERS_U2 : S_IDLE;
            end
            S_ERS_U2: begin
                if (wr_en) state_d = (at_key2 && wdata == KEY2) ? S_ERS_CMD : S_IDLE;
            end
            S_ERS_CMD: begin
                if (wr_en) state_d = (at_key1 && wdata == CODE_CHIP_ERS) ? S_ERS_PRE : S_IDLE;
            end
            S_IDENT: begin
                if (wr_en && is_reset) state_d = S_IDLE;
            end
            S_PGM_BUSY: begin
                if (tdone) state_d = bad_q ? S_FAIL : S_IDLE;
            end
            S_ERS_PRE: begin
                if (tdone) state_d = S_ERS_MAIN;
            end
            S_ERS_MAIN: begin
                if (tdone) state_d = S_IDLE;
            end
            S_FAIL: begin
                if (wr_en && is_reset) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Output logic.
    always_comb begin
        rd_sel   = SEL_ARRAY;
        st_dq7   = 1'b0;
        st_dq5   = 1'b0;
        st_ers   = 1'b0;
        t_start  = 1'b0;
        t_len    = CNT_W'(PGM_CYC);
        pgm_en   = 1'b0;
        fill_en  = 1'b0;
        fill_val = 8'hFF;
        unique case (state_q)
            S_IDENT: rd_sel = SEL_IDENT;
            S_PGM_SETUP: begin
                if (wr_en) begin
                    pgm_en  = 1'b1;
                    t_start = 1'b1;
                end
            end
            S_ERS_CMD: begin
                if (wr_en && at_key1 && wdata == CODE_CHIP_ERS) begin
                    t_start = 1'b1;
                    t_len   = CNT_W'(PRE_CYC);
                end
            end
            S_PGM_BUSY: begin
                rd_sel = SEL_STATUS;
                st_dq7 = ~pbit7_q;
            end
            S_FAIL: begin
                rd_sel = SEL_STATUS;
                st_dq7 = ~pbit7_q;
                st_dq5 = 1'b1;
            end
            S_ERS_PRE: begin
                rd_sel = SEL_STATUS;
                st_ers = 1'b1;
                if (tdone) begin
                    fill_en  = 1'b1;
                    fill_val = 8'h00;
                    t_start  = 1'b1;
                    t_len    = CNT_W'(ERS_CYC);
                end
            end
            S_ERS_MAIN: begin
                rd_sel = SEL_STATUS;
                st_ers = 1'b1;
                if (tdone) fill_en = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_cmd_pkg::*;
#(
    parameter logic [7:0] MFG_ID = 8'h7F,
    parameter logic [7:0] DEV_ID = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  rd_sel_t    sel,
    input  logic [7:0] arr_data,
    input  logic [1:0] addr_lo,
    input  logic       dq7,
    input  logic       dq5,
    input  logic       ers,
    output logic [7:0] rdata
);

    logic tog_q;

    // The toggle is held at 0 outside status mode, so every busy period
    // starts its toggle from a known value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (sel != SEL_STATUS) begin
            tog_q <= 1'b0;
        end else if (rd_en) begin
            tog_q <= ~tog_q;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_IDENT: begin
                rdata = 8'h00;
                if (addr_lo == 2'd0) rdata = MFG_ID;
                if (addr_lo == 2'd1) rdata = DEV_ID;
            end
            SEL_STATUS: rdata = {dq7, tog_q, dq5, 2'b00, ers & tog_q, 2'b00};
            default:    rdata = arr_data;
        endcase
    end

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W    = 11,
    parameter int         MEM_DEPTH = 16,
    parameter int         PGM_CYC   = 8,
    parameter int         PRE_CYC   = 16,
    parameter int         ERS_CYC   = 24,
    parameter logic [7:0] MFG_ID    = 8'h7F,
    parameter logic [7:0] DEV_ID    = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int MEM_AW  = $clog2(MEM_DEPTH);
    localparam int MAX_CYC = (PGM_CYC > PRE_CYC) ?
                             ((PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC) :
                             ((PRE_CYC > ERS_CYC) ? PRE_CYC : ERS_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             wr_en, rd_en;
    logic [7:0]       cell_q;
    logic             tdone, t_start;
    logic [CNT_W-1:0] t_len;
    logic             pgm_en, fill_en;
    logic [7:0]       fill_val;
    logic             st_dq7, st_dq5, st_ers;
    rd_sel_t          rd_sel;
    fsm_state_t       state;

    assign wr_en = cs & we;
    assign rd_en = cs & rd;

    flash_cmd_fsm #(
        .CNT_W  (CNT_W),
        .PGM_CYC(PGM_CYC),
        .PRE_CYC(PRE_CYC),
        .ERS_CYC(ERS_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr_lo (addr[10:0]),
        .wdata   (wdata),
        .cell_q  (cell_q),
        .tdone   (tdone),
        .state   (state),
        .rd_sel  (rd_sel),
        .st_dq7  (st_dq7),
        .st_dq5  (st_dq5),
        .st_ers  (st_ers),
        .t_start (t_start),
        .t_len   (t_len),
        .pgm_en  (pgm_en),
        .fill_en (fill_en),
        .fill_val(fill_val)
    );

    flash_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(t_start),
        .len  (t_len),
        .done (tdone)
    );

    flash_mem_array #(.DEPTH(MEM_DEPTH), .AW(MEM_AW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (addr[MEM_AW-1:0]),
        .cell_q  (cell_q),
        .pgm_en  (pgm_en),
        .pgm_data(wdata),
        .fill_en (fill_en),
        .fill_val(fill_val)
    );

    flash_read_mux #(.MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_rmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .sel     (rd_sel),
        .arr_data(cell_q),
        .addr_lo (addr[1:0]),
        .dq7     (st_dq7),
        .dq5     (st_dq5),
        .ers     (st_ers),
        .rdata   (rdata)
    );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
    import flash_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       we,
    input logic       rd,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input fsm_state_t state,
    input logic       tdone
);

    logic wr_c, rd_c, stat_c;

    assign wr_c   = cs & we;
    assign rd_c   = cs & rd;
    assign stat_c = (state == S_PGM_BUSY) || (state == S_FAIL) ||
                    (state == S_ERS_PRE)  || (state == S_ERS_MAIN);

    // R3: identification mode survives every write except the reset code.
    assert_ident_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDENT && !(wr_c && wdata == CODE_RESET)) |=> state == S_IDENT);

    // R6: the program status byte has its low bits and timeout bit clear.
    assert_pgm_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PGM_BUSY) |-> (rdata[5:0] == 6'd0));

    // R6: in status mode, bit 6 inverts after every read.
    assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && stat_c) |=> (!stat_c || rdata[6] != $past(rdata[6])));

    // R7: the timeout state is left only by the reset code.
    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FAIL && !(wr_c && wdata == CODE_RESET)) |=> state == S_FAIL);

    // R8: the end of the main erase phase returns the block to array reads.
    assert_erase_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERS_MAIN && tdone) |=> state == S_IDLE);

    // R10: before the timer expires, no write moves the block out of erase.
    assert_erase_deaf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERS_MAIN && !tdone) |=> state == S_ERS_MAIN);

    // R9: the erase status keeps bit 7 low.
    assert_erase_dq7_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERS_PRE || state == S_ERS_MAIN) |-> !rdata[7]);

endmodule

bind flash_cmd_top flash_cmd_checker u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs   (cs),
    .we   (we),
    .rd   (rd),
    .wdata(wdata),
    .rdata(rdata),
    .state(state),
    .tdone(tdone)
);

// File: tb/tb_flash_cmd_top.sv
module tb_flash_cmd_top;

    localparam int  CLK_PS = 5000;
    localparam int  NV     = 64;
    localparam logic [1:0] OW = 2'd0;
    localparam logic [1:0] OR = 2'd1;
    localparam logic [1:0] OT = 2'd2;

    // Entry layout: {op, requirement, addr, data, expected}
    localparam logic [32:0] VEC [NV] = '{
        {OR, 4'd1,  11'h003, 8'h00, 8'hFF},  // R1 reset contents
        {OW, 4'd3,  11'h555, 8'hAA, 8'h00},  // R3 enter identification
        {OW, 4'd3,  11'h2AA, 8'h55, 8'h00},
        {OW, 4'd3,  11'h555, 8'h90, 8'h00},
        {OR, 4'd3,  11'h000, 8'h00, 8'h7F},
        {OR, 4'd3,  11'h001, 8'h00, 8'hA5},
        {OR, 4'd3,  11'h002, 8'h00, 8'h00},
        {OW, 4'd3,  11'h123, 8'h00, 8'h00},
        {OR, 4'd3,  11'h001, 8'h00, 8'hA5},
        {OW, 4'd3,  11'h000, 8'hF0, 8'h00},
        {OR, 4'd3,  11'h003, 8'h00, 8'hFF},
        {OW, 4'd5,  11'h555, 8'hAA, 8'h00},  // R5 program 0x5A at 3
        {OW, 4'd5,  11'h2AA, 8'h55, 8'h00},
        {OW, 4'd5,  11'h555, 8'hA0, 8'h00},
        {OW, 4'd5,  11'h003, 8'h5A, 8'h00},
        {OR, 4'd6,  11'h003, 8'h00, 8'h80},  // R6 status
        {OR, 4'd6,  11'h003, 8'h00, 8'hC0},
        {OT, 4'd5,  11'h000, 8'd10, 8'h00},
        {OR, 4'd5,  11'h003, 8'h00, 8'h5A},
        {OW, 4'd7,  11'h555, 8'hAA, 8'h00},  // R7 program 0xA5 over 0x5A
        {OW, 4'd7,  11'h2AA, 8'h55, 8'h00},
        {OW, 4'd7,  11'h555, 8'hA0, 8'h00},
        {OW, 4'd7,  11'h003, 8'hA5, 8'h00},
        {OR, 4'd6,  11'h003, 8'h00, 8'h00},
        {OR, 4'd6,  11'h003, 8'h00, 8'h40},
        {OT, 4'd7,  11'h000, 8'd10, 8'h00},
        {OR, 4'd7,  11'h003, 8'h00, 8'h20},
        {OW, 4'd7,  11'h000, 8'h55, 8'h00},
        {OR, 4'd7,  11'h003, 8'h00, 8'h60},
        {OW, 4'd7,  11'h000, 8'hF0, 8'h00},
        {OR, 4'd7,  11'h003, 8'h00, 8'h00},
        {OW, 4'd4,  11'h555, 8'hAA, 8'h00},  // R4 abort after first unlock
        {OW, 4'd4,  11'h000, 8'hF0, 8'h00},
        {OW, 4'd4,  11'h005, 8'h00, 8'h00},
        {OR, 4'd4,  11'h005, 8'h00, 8'hFF},
        {OW, 4'd4,  11'h555, 8'hAA, 8'h00},  // R4 abort after second unlock
        {OW, 4'd4,  11'h2AA, 8'h55, 8'h00},
        {OW, 4'd4,  11'h555, 8'hF0, 8'h00},
        {OW, 4'd4,  11'h005, 8'h00, 8'h00},
        {OR, 4'd4,  11'h005, 8'h00, 8'hFF},
        {OW, 4'd2,  11'h555, 8'hAA, 8'h00},  // R2 unknown code
        {OW, 4'd2,  11'h2AA, 8'h55, 8'h00},
        {OW, 4'd2,  11'h555, 8'h33, 8'h00},
        {OW, 4'd2,  11'h005, 8'h00, 8'h00},
        {OR, 4'd2,  11'h005, 8'h00, 8'hFF},
        {OW, 4'd5,  11'h555, 8'hAA, 8'h00},  // R5 program 0x0F at 5
        {OW, 4'd5,  11'h2AA, 8'h55, 8'h00},
        {OW, 4'd5,  11'h555, 8'hA0, 8'h00},
        {OW, 4'd5,  11'h005, 8'h0F, 8'h00},
        {OT, 4'd5,  11'h000, 8'd10, 8'h00},
        {OR, 4'd5,  11'h005, 8'h00, 8'h0F},
        {OW, 4'd8,  11'h555, 8'hAA, 8'h00},  // R8 chip erase
        {OW, 4'd8,  11'h2AA, 8'h55, 8'h00},
        {OW, 4'd8,  11'h555, 8'h80, 8'h00},
        {OW, 4'd8,  11'h555, 8'hAA, 8'h00},
        {OW, 4'd8,  11'h2AA, 8'h55, 8'h00},
        {OW, 4'd8,  11'h555, 8'h10, 8'h00},
        {OR, 4'd9,  11'h005, 8'h00, 8'h00},  // R9 erase status
        {OR, 4'd9,  11'h005, 8'h00, 8'h44},
        {OW, 4'd10, 11'h555, 8'hF0, 8'h00},  // R10 ignored while busy
        {OR, 4'd10, 11'h005, 8'h00, 8'h00},
        {OT, 4'd8,  11'h000, 8'd50, 8'h00},
        {OR, 4'd8,  11'h005, 8'h00, 8'hFF},
        {OR, 4'd10, 11'h003, 8'h00, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0, rd = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PS / 2 * 1ps) clk = ~clk;

    flash_cmd_top dut (
        .clk  (clk),
        .rst_n(rst_n),
        .cs   (cs),
        .we   (we),
        .rd   (rd),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata)
    );

    task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1ps;
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1ps;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL R%0d: addr %h read %h, expected %h", req, a, rdata, exp);
        end
        @(posedge clk);
        #1ps;
        cs = 1'b0; rd = 1'b0;
    endtask

    initial begin
        #(CLK_PS * 200000 * 1ps);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [10:0] a;
            logic [7:0]  d, e;
            {op, rq, a, d, e} = VEC[i];
            case (op)
                OW:      bus_write(a, d);
                OR:      bus_read(a, e, int'(rq));
                default: repeat (int'(d)) @(negedge clk);
            endcase
        end

        // R1: a reset during identification mode restores array reads.
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h555, 8'h90);
        bus_read(11'h000, 8'h7F, 3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(11'h000, 8'hFF, 1);  // R1

        // R2: an unlock with the wrong address for the second key is dropped.
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AB, 8'h55);
        bus_write(11'h555, 8'h90);
        bus_read(11'h001, 8'hFF, 2);  // R2

        // R10: a program write during a running program is ignored.
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h555, 8'hA0);
        bus_write(11'h006, 8'hF3);
        bus_write(11'h006, 8'h00);
        repeat (10) @(negedge clk);
        bus_read(11'h006, 8'hF3, 10);  // R10

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule